// File: doc/BRIEF.md
# Dual-Threshold Compare and Fail Tally

This block sits on one tester channel, after the two threshold comparators and
next to the waveform sequencer. On every compare strobe it takes the two
comparator results from that moment, one for above the high threshold and one
for below the low threshold, and checks them against the response the pattern
expects. A mismatch produces a one-cycle fail pulse and adds one to a
saturating fail tally. The same strobe also shifts the device's sampled logic
state into a short history register, which receive-memory logic can read.

The strobe is a valid/ready stream. A strobe counts only in a cycle where
`cmp_valid` and `cmp_ready` are both high. `cmp_ready` is low while reset is
held and from the first clock after reset it stays high. This means the block
never applies back-pressure during operation. When `cmp_valid` is low, the
other stream inputs are don't-care. A small register port reads the tally and
the capture history. The same port clears both of them.

Top module: `cmp_fail_unit`

## Requirements
- R1: After reset, `fail_flag` is 0, `fail_count` is 0 and `capture` is 0. `cmp_ready` is 0 during reset and 1 from the first clock edge after reset is released.
- R2: The expect code on `exp_code` is one of four values. 0 means low: the low comparator must be 1. 1 means high: the high comparator must be 1. 2 means mid: both comparators must be 0. 3 means mask: the strobe never fails.
- R3: `fail_flag` is registered. It is 1 for exactly the one cycle after an accepted strobe that fails, and 0 otherwise.
- R4: Each failing accepted strobe increments `fail_count` by one, at the same clock edge that raises `fail_flag`.
- R5: `fail_count` saturates at all ones. A further fail leaves it at all ones.
- R6: Each accepted strobe shifts the value of `cmp_hi` into bit 0 of `capture`. Older samples move toward the MSB.
- R7: A register write to address 0 with `reg_wdata` bit 0 set clears `fail_count` and `capture` at the next edge. The clear wins over an increment or a shift in the same cycle. `fail_flag` still reports that cycle's strobe.
- R8: `reg_rdata` shows `fail_count` zero-extended at address 0 and `capture` zero-extended at address 1. A write to address 1, or a write to address 0 with bit 0 clear, changes nothing.
- R9: A cycle with `cmp_valid` low causes no fail pulse, no count change and no shift, whatever the comparator inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe present this cycle |
| cmp_ready | output | 1 | Strobe can be accepted |
| exp_code | input | 2 | Expected response code (low, high, mid, mask) |
| cmp_hi | input | 1 | Comparator result, above high threshold |
| cmp_lo | input | 1 | Comparator result, below low threshold |
| fail_flag | output | 1 | One-cycle pulse for a failed strobe |
| fail_count | output | CNT_W | Saturating fail tally |
| capture | output | CAP_W | Sampled-state history, newest in bit 0 |
| reg_addr | input | 1 | Register select: 0 = tally, 1 = capture |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data; bit 0 at address 0 clears |
| reg_rdata | output | DATA_W | Read data for the selected register |

## Verification
The bound assertions check the following on every cycle: the fail pulse timing against the strobe and expect code, the single-step increment of the tally, that it holds once at all ones, that a clear empties both registers, and the shift of `cmp_hi` into the history. The bench scenarios show the rest. The full table of expect codes against comparator pairs shows the pass/fail decision. A narrowed tally shows saturation. The read path, the writes that must be ignored, and the case of a clear colliding with a failing strobe are also shown only by the bench.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    EXP_LOW  = 2'd0,
    EXP_HIGH = 2'd1,
    EXP_MID  = 2'd2,
    EXP_MASK = 2'd3
  } exp_code_e;

  localparam logic ADDR_TALLY   = 1'b0;
  localparam logic ADDR_CAPTURE = 1'b1;

endpackage

// File: rtl/cfu_judge.sv
module cfu_judge
  import cfu_pkg::*;
(
  input  logic      take,
  input  exp_code_e code,
  input  logic      hi,
  input  logic      lo,
  output logic      miss
);

  logic mismatch;

  always_comb begin
    unique case (code)
      EXP_LOW:  mismatch = ~lo;
      EXP_HIGH: mismatch = ~hi;
      EXP_MID:  mismatch = hi | lo;
      default:  mismatch = 1'b0;
    endcase
  end

  assign miss = take & mismatch;

endmodule

// File: rtl/cfu_sat_counter.sv
module cfu_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (inc && !at_top) cnt <= cnt + ONE;
  end

endmodule

// File: rtl/cfu_capture_shift.sv
module cfu_capture_shift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  generate
    if (W == 1) begin : g_single
      assign nxt = din;
    end else begin : g_multi
      assign nxt = {q[W-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (shift) q <= nxt;
  end

endmodule

// File: rtl/cfu_regport.sv
module cfu_regport
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CAP_W  = 4
) (
  input  logic              addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  tally,
  input  logic [CAP_W-1:0]  hist,
  output logic              clr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] tally_ext;
  logic [DATA_W-1:0] hist_ext;

  generate
    if (CNT_W == DATA_W) begin : g_tally_full
      assign tally_ext = tally;
    end else begin : g_tally_pad
      assign tally_ext = {{(DATA_W-CNT_W){1'b0}}, tally};
    end
    if (CAP_W == DATA_W) begin : g_hist_full
      assign hist_ext = hist;
    end else begin : g_hist_pad
      assign hist_ext = {{(DATA_W-CAP_W){1'b0}}, hist};
    end
  endgenerate

  assign clr   = wr & (addr == ADDR_TALLY) & wdata[0];
  assign rdata = (addr == ADDR_CAPTURE) ? hist_ext : tally_ext;

endmodule

// File: rtl/cmp_fail_unit.sv
module cmp_fail_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [1:0]        exp_code,
  input  logic              cmp_hi,
  input  logic              cmp_lo,
  output logic              fail_flag,
  output logic [CNT_W-1:0]  fail_count,
  output logic [CAP_W-1:0]  capture,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  logic ready_q;
  logic take;
  logic miss;
  logic clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign cmp_ready = ready_q;
  assign take      = cmp_valid & ready_q;

  cfu_judge u_judge (
    .take (take),
    .code (exp_code_e'(exp_code)),
    .hi   (cmp_hi),
    .lo   (cmp_lo),
    .miss (miss)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_flag <= 1'b0;
    else        fail_flag <= miss;
  end

  cfu_sat_counter #(.W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (miss),
    .cnt   (fail_count)
  );

  cfu_capture_shift #(.W(CAP_W)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .shift (take),
    .din   (cmp_hi),
    .q     (capture)
  );

  cfu_regport #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CAP_W(CAP_W)) u_regs (
    .addr  (reg_addr),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .tally (fail_count),
    .hist  (capture),
    .clr   (clr),
    .rdata (reg_rdata)
  );

endmodule

// File: rtl/cmp_fail_unit_chk.sv
module cmp_fail_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CAP_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic              cmp_ready,
  input logic [1:0]        exp_code,
  input logic              cmp_hi,
  input logic              cmp_lo,
  input logic              fail_flag,
  input logic [CNT_W-1:0]  fail_count,
  input logic [CAP_W-1:0]  capture,
  input logic              reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata
);

  logic acc;
  logic bad;
  logic wipe;
  assign acc  = cmp_valid && cmp_ready;
  assign bad  = acc && ((exp_code == 2'd0 && !cmp_lo) ||
                        (exp_code == 2'd1 && !cmp_hi) ||
                        (exp_code == 2'd2 && (cmp_hi || cmp_lo)));
  assign wipe = reg_wr && !reg_addr && reg_wdata[0];

  a_r3_flag_tracks_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag == $past(bad));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !wipe && fail_count != {CNT_W{1'b1}})
      |=> fail_count == $past(fail_count) + 1'b1);

  a_r5_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_count == {CNT_W{1'b1}} && !wipe) |=> fail_count == {CNT_W{1'b1}});

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (fail_count == '0 && capture == '0));

  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wipe) |=> capture[0] == $past(cmp_hi));

  a_r9_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !wipe) |=> ($stable(fail_count) && $stable(capture) && !fail_flag));

endmodule

bind cmp_fail_unit cmp_fail_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CAP_W(CAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_valid  (cmp_valid),
  .cmp_ready  (cmp_ready),
  .exp_code   (exp_code),
  .cmp_hi     (cmp_hi),
  .cmp_lo     (cmp_lo),
  .fail_flag  (fail_flag),
  .fail_count (fail_count),
  .capture    (capture),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata)
);

// File: tb/sim_cmp_fail_unit.sv
module sim_cmp_fail_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int CAP_W  = 4;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // entry: {exp_code[1:0], hi, lo, expected_fail}
  localparam logic [4:0] VEC [16] = '{
    5'b00_00_1, 5'b00_01_0, 5'b00_10_1, 5'b00_11_0,
    5'b01_00_1, 5'b01_01_1, 5'b01_10_0, 5'b01_11_0,
    5'b10_00_0, 5'b10_01_1, 5'b10_10_1, 5'b10_11_1,
    5'b11_00_0, 5'b11_01_0, 5'b11_10_0, 5'b11_11_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0;
  logic cmp_ready;
  logic [1:0] exp_code = 2'd0;
  logic cmp_hi = 1'b0;
  logic cmp_lo = 1'b0;
  logic fail_flag;
  logic [CNT_W-1:0] fail_count;
  logic [CAP_W-1:0] capture;
  logic reg_addr = 1'b0;
  logic reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_cnt = 0;
  logic [CAP_W-1:0] exp_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_fail_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CAP_W(CAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .exp_code(exp_code), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .fail_flag(fail_flag), .fail_count(fail_count), .capture(capture),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // One strobe: drive at negedge, result visible at the following negedge.
  task automatic strobe(input logic [1:0] code, input logic hi, input logic lo, input logic wipe);
    @(negedge clk);
    cmp_valid = 1'b1; exp_code = code; cmp_hi = hi; cmp_lo = lo;
    reg_wr = wipe; reg_addr = 1'b0; reg_wdata = wipe ? 32'd1 : 32'd0;
    @(negedge clk);
    cmp_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic model_fail(input logic [1:0] code, input logic hi, input logic lo);
    case (code)
      2'd0: return !lo;
      2'd1: return !hi;
      2'd2: return hi || lo;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void model_take(input logic [1:0] code, input logic hi, input logic lo);
    if (model_fail(code, hi, lo) && exp_cnt < int'(TOP)) exp_cnt++;
    exp_cap = {exp_cap[CAP_W-2:0], hi};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 1);
    check("R1 ready in reset", {31'd0, cmp_ready}, 32'd0);
    check("R1 flag", {31'd0, fail_flag}, 32'd0);
    check("R1 count", {28'd0, fail_count}, 32'd0);
    check("R1 capture", {28'd0, capture}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, cmp_ready}, 32'd1);

    // R2 R3 R4 R6 table walk
    foreach (VEC[i]) begin
      strobe(VEC[i][4:3], VEC[i][2], VEC[i][1], 1'b0);
      check($sformatf("R2 R3 flag vec %0d", i), {31'd0, fail_flag}, {31'd0, VEC[i][0]});
      model_take(VEC[i][4:3], VEC[i][2], VEC[i][1]);
      check($sformatf("R4 count vec %0d", i), {28'd0, fail_count}, exp_cnt);
      check($sformatf("R6 capture vec %0d", i), {28'd0, capture}, {28'd0, exp_cap});
      @(negedge clk);
      check("R3 flag one cycle", {31'd0, fail_flag}, 32'd0);
    end

    // R8 reads
    reg_addr = 1'b0; #1;
    check("R8 read tally", reg_rdata, exp_cnt);
    reg_addr = 1'b1; #1;
    check("R8 read capture", reg_rdata, {28'd0, exp_cap});

    // R8 ignored writes
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); reg_addr = 1'b0; reg_wdata = 32'hFFFF_FFFE;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    check("R8 ignored write count", {28'd0, fail_count}, exp_cnt);
    check("R8 ignored write capture", {28'd0, capture}, {28'd0, exp_cap});

    // R9 no valid
    @(negedge clk); exp_code = 2'd1; cmp_hi = 1'b0; cmp_lo = 1'b1;
    @(negedge clk);
    check("R9 no flag", {31'd0, fail_flag}, 32'd0);
    check("R9 count held", {28'd0, fail_count}, exp_cnt);
    check("R9 capture held", {28'd0, capture}, {28'd0, exp_cap});

    // R5 saturation
    for (int k = 0; k < 20; k++) begin
      strobe(2'd1, 1'b0, 1'b0, 1'b0);
      model_take(2'd1, 1'b0, 1'b0);
    end
    check("R5 saturated", {28'd0, fail_count}, {28'd0, TOP});
    strobe(2'd2, 1'b1, 1'b1, 1'b0);
    model_take(2'd2, 1'b1, 1'b1);
    check("R5 stays at top", {28'd0, fail_count}, {28'd0, TOP});
    check("R5 flag at top", {31'd0, fail_flag}, 32'd1);

    // R7 clear collides with a failing strobe
    strobe(2'd0, 1'b1, 1'b0, 1'b1);
    exp_cnt = 0; exp_cap = '0;
    check("R7 flag still reported", {31'd0, fail_flag}, 32'd1);
    check("R7 count cleared", {28'd0, fail_count}, 32'd0);
    check("R7 capture cleared", {28'd0, capture}, 32'd0);
    strobe(2'd1, 1'b1, 1'b0, 1'b0);
    model_take(2'd1, 1'b1, 1'b0);
    check("R6 shift after clear", {28'd0, capture}, {28'd0, exp_cap});
    check("R4 pass after clear", {28'd0, fail_count}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule